// File: doc/BRIEF.md
# Bitmap Bit Read-Modify-Write Engine

This engine performs a single bit operation on a bitmap that lives in word-addressed memory. The caller gives it a bitmap base address, an unsigned bit index and an operation code on a one-cycle start pulse. The engine splits the index into a word offset and a bit position, then drives one memory port to complete the operation. Set, clear and flip read the word, change the selected bit and write the word back. Test only reads the word and reports the selected bit through a zero flag.

The memory port has a single master. The engine holds a request with a fixed address, write enable and write data until the memory returns ready. An access completes on the clock edge where request and ready are both high, so the memory may add any number of wait states. For the three modifying operations a lock output keeps other masters off the bus from the read until the write is accepted. The start, done and flag pins are plain control signals. Start is not back-pressured: while an operation runs, further start pulses are dropped.

Top module: `bitmap_rmw_engine`

## Requirements
- R1: The word address is `base_addr + (bit_index >> 5)` modulo 2^32, and the bit position is `bit_index[4:0]`. The index is treated as unsigned, so index 0xFFFFFFFF with base 0x10 addresses word 0x0800000F, bit 31.
- R2: Op code 0 (set) reads the word and writes it back with the selected bit forced to 1 and every other bit unchanged.
- R3: Op code 1 (clear) reads the word and writes it back with the selected bit forced to 0 and every other bit unchanged.
- R4: Op code 2 (flip) reads the word and writes it back with the selected bit inverted and every other bit unchanged.
- R5: Op code 3 (test) issues only a read, never writes and never asserts `mem_lock`. At completion `zero_flag` equals the inverse of the selected bit. Other op codes leave `zero_flag` unchanged, and it is 0 after reset.
- R6: For op codes 0 to 2, `mem_lock` is high in the first cycle of the read request. It stays high through the write and falls in the cycle after the write is accepted.
- R7: An access completes on the rising edge where `mem_req` and `mem_ready` are both high. Until then `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay constant, for any number of wait states.
- R8: A start pulse that arrives while an operation is in progress is ignored. It changes neither the operation, the address nor memory.
- R9: A start pulse while idle raises the read request in the next cycle. `done` is high for exactly one cycle, the cycle after the final access completes.
- R10: During and right after reset, `mem_req`, `mem_lock`, `done` and `zero_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that launches an operation |
| op | input | 2 | 0 set, 1 clear, 2 flip, 3 test |
| base_addr | input | 32 | Word address of the start of the bitmap |
| bit_index | input | 32 | Unsigned bit number relative to the base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_lock | output | 1 | Bus lock held across a read-modify-write |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid when `mem_ready` is high |
| mem_ready | input | 1 | Memory completes the current access |
| done | output | 1 | One-cycle completion pulse |
| zero_flag | output | 1 | Inverse of the bit read by the last test |

## Verification
After a start pulse the read request is due one cycle later. Each access lasts as many cycles as the memory holds off ready, plus one. The write request follows in the cycle after the read completes, and `done` together with the updated `zero_flag` follows in the cycle after the last access. The bench keeps a behavioural model that moves through those phases on the same edges and uses the same ready and read data. On every falling edge it compares all outputs with the model, so a result one cycle early or late is caught. After each operation the bench checks the memory word against a value it computes from the word's earlier contents.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  typedef enum logic [1:0] {
    BMR_SET  = 2'd0,
    BMR_CLR  = 2'd1,
    BMR_FLIP = 2'd2,
    BMR_TEST = 2'd3
  } bmr_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } bmr_state_e;
endpackage

// File: rtl/bmr_addr_calc.sv
module bmr_addr_calc #(
  parameter int AW = 32,
  parameter int IW = 32,
  parameter int DW = 32
) (
  input  logic [AW-1:0]          base,
  input  logic [IW-1:0]          idx,
  output logic [AW-1:0]          word_addr,
  output logic [$clog2(DW)-1:0]  bit_pos
);
  localparam int SHW = $clog2(DW);
  localparam int OFW = IW - SHW;

  logic [AW-1:0] offset;

  // The offset width follows the index width; pick the fitting variant.
  generate
    if (OFW >= AW) begin : g_trunc
      assign offset = idx[SHW +: AW];
    end else begin : g_ext
      assign offset = {{(AW-OFW){1'b0}}, idx[IW-1:SHW]};
    end
  endgenerate

  assign word_addr = base + offset;
  assign bit_pos   = idx[SHW-1:0];
endmodule

// File: rtl/bmr_bit_alu.sv
module bmr_bit_alu
  import bmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]          word_in,
  input  logic [$clog2(DW)-1:0]  pos,
  input  bmr_op_e                op,
  output logic [DW-1:0]          word_out,
  output logic                   sel_bit
);
  localparam int SHW = $clog2(DW);

  genvar i;
  generate
    for (i = 0; i < DW; i++) begin : g_bit
      localparam logic [SHW-1:0] MYPOS = SHW'(i);
      logic hit;
      assign hit = (pos == MYPOS);
      always_comb begin
        word_out[i] = word_in[i];
        if (hit) begin
          case (op)
            BMR_SET:  word_out[i] = 1'b1;
            BMR_CLR:  word_out[i] = 1'b0;
            BMR_FLIP: word_out[i] = ~word_in[i];
            default:  word_out[i] = word_in[i];
          endcase
        end
      end
    end
  endgenerate

  assign sel_bit = word_in[pos];
endmodule

// File: rtl/bmr_ctrl.sv
module bmr_ctrl
  import bmr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic [1:0] op_in,
  input  logic    mem_ready,
  output bmr_op_e op_q,
  output logic    load_cmd,
  output logic    load_data,
  output logic    upd_zero,
  output logic    req,
  output logic    we,
  output logic    lock,
  output logic    done
);
  bmr_state_e state;
  logic       is_test;

  assign is_test = (op_q == BMR_TEST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q  <= BMR_SET;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            op_q  <= bmr_op_e'(op_in);
            state <= ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ready) begin
            if (is_test) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state <= ST_WRITE;
            end
          end
        end
        ST_WRITE: begin
          if (mem_ready) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign load_cmd  = (state == ST_IDLE) && start;
  assign load_data = (state == ST_READ) && mem_ready && !is_test;
  assign upd_zero  = (state == ST_READ) && mem_ready && is_test;
  assign req       = (state != ST_IDLE);
  assign we        = (state == ST_WRITE);
  assign lock      = (state == ST_WRITE) || ((state == ST_READ) && !is_test);
endmodule

// File: rtl/bitmap_rmw_engine.sv
module bitmap_rmw_engine
  import bmr_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [AW-1:0] base_addr,
  input  logic [IW-1:0] bit_index,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_lock,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          done,
  output logic          zero_flag
);
  localparam int SHW = $clog2(DW);

  bmr_op_e        op_q;
  logic           load_cmd, load_data, upd_zero;
  logic [AW-1:0]  calc_addr, addr_q;
  logic [SHW-1:0] calc_pos, pos_q;
  logic [DW-1:0]  new_word, wdata_q;
  logic           sel_bit, zero_q;

  bmr_addr_calc #(.AW(AW), .IW(IW), .DW(DW)) u_addr (
    .base      (base_addr),
    .idx       (bit_index),
    .word_addr (calc_addr),
    .bit_pos   (calc_pos)
  );

  bmr_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_in     (op),
    .mem_ready (mem_ready),
    .op_q      (op_q),
    .load_cmd  (load_cmd),
    .load_data (load_data),
    .upd_zero  (upd_zero),
    .req       (mem_req),
    .we        (mem_we),
    .lock      (mem_lock),
    .done      (done)
  );

  bmr_bit_alu #(.DW(DW)) u_alu (
    .word_in  (mem_rdata),
    .pos      (pos_q),
    .op       (op_q),
    .word_out (new_word),
    .sel_bit  (sel_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      pos_q   <= '0;
      wdata_q <= '0;
      zero_q  <= 1'b0;
    end else begin
      if (load_cmd) begin
        addr_q <= calc_addr;
        pos_q  <= calc_pos;
      end
      if (load_data) wdata_q <= new_word;
      if (upd_zero)  zero_q  <= ~sel_bit;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign zero_flag = zero_q;
endmodule

// File: rtl/bmr_checker.sv
module bmr_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_lock,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic [1:0]    op_q
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr));

  // R6
  write_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_lock);

  // R6
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ready |=> !mem_lock);

  // R5
  test_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && (op_q == 2'd3) |-> !mem_lock && !mem_we);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);
endmodule

bind bitmap_rmw_engine bmr_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_lock  (mem_lock),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .done      (done),
  .op_q      (op_q)
);

// File: tb/bitmap_rmw_engine_tb.sv
`timescale 1ns/1ps
module bitmap_rmw_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [31:0] base_addr = '0;
  logic [31:0] bit_index = '0;
  logic        mem_req, mem_we, mem_lock, done, zero_flag;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 32'hDEAD_BEEF;
  logic        mem_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int waits_cfg = 1;
  int wcnt = 0;
  logic [31:0] mem [int unsigned];

  bitmap_rmw_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .base_addr(base_addr), .bit_index(bit_index),
    .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .done(done), .zero_flag(zero_flag)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a * 32'h9E37_79B1;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge.
  int          m_phase = 0;   // 0 idle, 1 reading, 2 writing
  int          m_op = 0;
  logic [31:0] m_addr = '0;
  int          m_bit = 0;
  logic [31:0] m_wd = '0;
  logic        m_done = 1'b0;
  logic        m_zero = 1'b0;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_phase = 0; m_done = 0; m_zero = 0; m_addr = '0; m_wd = '0;
    end else begin
      m_done = 0;
      if (m_phase == 0) begin
        if (start) begin
          m_op = op;
          m_addr = base_addr + (bit_index >> 5);
          m_bit = bit_index % 32;
          m_phase = 1;
        end
      end else if (m_phase == 1) begin
        if (mem_ready) begin
          if (m_op == 3) begin
            m_zero = !mem_rdata[m_bit];
            m_done = 1;
            m_phase = 0;
          end else begin
            m_wd = mem_rdata;
            if (m_op == 0) m_wd[m_bit] = 1'b1;
            else if (m_op == 1) m_wd[m_bit] = 1'b0;
            else m_wd[m_bit] = ~m_wd[m_bit];
            m_phase = 2;
          end
        end
      end else begin
        if (mem_ready) begin
          m_done = 1;
          m_phase = 0;
        end
      end
    end
  end

  // Compare every cycle, then act as the memory for the coming edge.
  always @(negedge clk) begin
    chk(mem_req == (m_phase != 0), "R9", "mem_req", 32'(mem_req), 32'(m_phase != 0));
    chk(mem_lock == (m_phase == 2 || (m_phase == 1 && m_op != 3)), "R6", "mem_lock",
        32'(mem_lock), 32'(m_phase == 2 || (m_phase == 1 && m_op != 3)));
    chk(done == m_done, "R9", "done", 32'(done), 32'(m_done));
    chk(zero_flag == m_zero, "R5", "zero_flag", 32'(zero_flag), 32'(m_zero));
    if (m_phase != 0) begin
      chk(mem_we == (m_phase == 2), "R7", "mem_we", 32'(mem_we), 32'(m_phase == 2));
      chk(mem_addr == m_addr, "R1", "mem_addr", mem_addr, m_addr);
      if (m_phase == 2) chk(mem_wdata == m_wd, "R7", "mem_wdata", mem_wdata, m_wd);
    end
    if (!rst_n || mem_ready) begin
      mem_ready = 1'b0;
      wcnt = 0;
      mem_rdata = 32'hDEAD_BEEF;
    end else if (mem_req) begin
      if (wcnt >= waits_cfg) begin
        mem_ready = 1'b1;
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata = mem_rd(mem_addr);
      end else begin
        wcnt++;
      end
    end
  end

  // One operation; optional second start pulse while busy.
  task automatic run_op(input int o, input logic [31:0] b, input logic [31:0] ix,
                        input int w, input bit glitch, input string tag);
    logic [31:0] a, old, exp, other_a, other_old;
    int p, n;
    a = b + (ix >> 5);
    p = ix % 32;
    old = mem_rd(a);
    exp = old;
    if (o == 0) exp[p] = 1'b1;
    else if (o == 1) exp[p] = 1'b0;
    else if (o == 2) exp[p] = ~old[p];
    other_a = a + 32'd5;
    other_old = mem_rd(other_a);
    @(negedge clk);
    waits_cfg = w;
    start = 1'b1; op = 2'(o); base_addr = b; bit_index = ix;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 50) begin
      if (glitch && n == 1) begin
        start = 1'b1; op = 2'((o + 1) % 4); bit_index = ix + 32'd160;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R9", "done seen", 32'(done), 32'd1);
    chk(mem_rd(a) == exp, tag, "memory word", mem_rd(a), exp);
    if (o == 3) chk(zero_flag == !old[p], "R5", "test zero", 32'(zero_flag), 32'(!old[p]));
    if (glitch) chk(mem_rd(other_a) == other_old, "R8", "untouched word",
                    mem_rd(other_a), other_old);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", 32'(done), 32'd0);
  endtask

  initial begin
    #1;
    chk(mem_req == 0 && mem_lock == 0 && done == 0 && zero_flag == 0, "R10", "reset outputs",
        {mem_req, mem_lock, done, zero_flag}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req == 0 && zero_flag == 0, "R10", "after reset", {mem_req, zero_flag}, 32'd0);
    mem[32'h1000 + 32'd218] = 32'h0000_0000;
    run_op(0, 32'h1000, 32'd7000, 1, 0, "R2");                   // set bit 24
    run_op(3, 32'h1000, 32'd7000, 2, 0, "R5");                   // test it, now 1
    run_op(1, 32'h1000, 32'd7000, 3, 0, "R3");                   // clear it
    run_op(3, 32'h1000, 32'd7000, 1, 0, "R5");                   // test it, now 0
    run_op(2, 32'h0000_0040, 32'd3, 1, 0, "R4");
    run_op(2, 32'h0000_0040, 32'd3, 4, 0, "R4");
    run_op(0, 32'h0000_0010, 32'hFFFF_FFFF, 2, 0, "R1");         // wraps to word 0x0800000F bit 31
    run_op(1, 32'hFFFF_FFF0, 32'd1023, 1, 0, "R1");              // address wrap modulo 2^32
    run_op(2, 32'h0000_2000, 32'd65, 2, 1, "R8");                // start while busy
    run_op(3, 32'h0000_2000, 32'd31, 3, 1, "R8");
    run_op(0, 32'h0000_0300, 32'd0, 0, 0, "R7");                 // no wait states
    for (int k = 0; k < 8; k++) run_op(k % 4, 32'h0000_5000 + 32'(k), 32'(k * 37), k % 3 + 1, 0, "R2");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule